// File: doc/BRIEF.md
# Slot-Based Frame Transmit Buffer

This block is the transmit half of a simple Ethernet MAC. A byte-addressed buffer memory is split into a fixed number of equal packet slots. Software polls a busy mask to find a free slot, writes one frame into that slot through the memory write port, and then issues a start request that carries the slot index and the frame length. Accepted requests are queued in a small request FIFO. A readout sequencer takes the oldest request and streams that slot's bytes on a byte-wide valid/ready/last interface.

A slot is marked busy when its start request is accepted. It becomes free again only after the handshake of its final byte. Finished frames raise a completion count. The pending flag is a level, not a pulse: it stays high while any completed frame has not been acknowledged, so a driver can service completions in a loop until the flag drops. Each acknowledge write removes one completion.

Top module: `pkt_slot_tx`

## Requirements
- R1: After reset, no slot is busy, the request level is 0, `req_ready` is 1, `tx_valid` is 0, `done_pending` is 0, `done_count` is 0 and `overflow` is 0.
- R2: An accepted start request sets bit `start_slot` of `slot_busy` and adds one entry to `req_level` at the next clock edge. `req_level` always equals the number of requests queued and not yet taken by the sequencer.
- R3: The memory write address is `{slot, offset}`, and `SLOT_BYTES` is a power of two. A frame of length L is sent as bytes at offsets 0 up to L-1 in rising order. `tx_last` is high on the byte at offset L-1 only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values on the next cycle.
- R5: A slot stays busy until the clock edge that completes the handshake of its last byte. From the following cycle it reads as free.
- R6: `req_ready` is high exactly when the request FIFO is not full. A start written while the FIFO is full is ignored: the level and busy mask do not change. Such a start sets `overflow`, and `overflow` stays set until reset.
- R7: A start with length 0, or with a length above `SLOT_BYTES`, is ignored. It marks no slot busy, queues nothing and sends no frame. A length equal to `SLOT_BYTES` is accepted.
- R8: A start that names a slot which is already busy is ignored. It queues nothing and sends no frame.
- R9: Queued frames are sent in the order their start requests were accepted.
- R10: Each finished frame adds one to `done_count`. `done_pending` is high exactly while `done_count` is nonzero. Each cycle with `ack_we` high and a nonzero count lowers the count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Buffer memory write strobe |
| mem_addr | input | SLOT_W+OFF_W | Write address, `{slot, offset}` |
| mem_wdata | input | 8 | Write data byte |
| start_we | input | 1 | Start request strobe |
| start_slot | input | SLOT_W | Slot index of the request |
| start_len | input | LEN_W | Frame length in bytes |
| slot_busy | output | NUM_SLOTS | Busy mask, one bit per slot |
| req_ready | output | 1 | Request FIFO has room |
| req_level | output | LVL_W | Queued request count |
| overflow | output | 1 | Sticky flag: a start was written while the FIFO was full |
| ack_we | input | 1 | Acknowledge one completion |
| done_pending | output | 1 | Level event: completions remain unacknowledged |
| done_count | output | DONE_W | Unacknowledged completion count |
| tx_data | output | 8 | Stream data byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
The bench fills the FIFO while the stream is stalled. A design whose ready flag or full check were off by one would either queue a request past capacity or fail to raise the sticky overflow flag. Starts with zero length, with a length one above the slot size, and with a slot that is already busy are each checked at the busy mask, the request level and the stream. A design that took any of them would show a busy bit, a queued entry or a frame with no owner. Frames of full slot size, a ready signal that drops every third cycle, and three queued frames drained in order catch an offset counter that wraps early, data that moves while stalled, and completions that are reordered or miscounted.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SEND = 1'b1} seq_state_e;

  // a frame length is usable when it is nonzero and fits in one slot
  function automatic logic len_in_range(input int unsigned len, input int unsigned cap);
    return (len != 0) && (len <= cap);
  endfunction

  // true on the byte offset that closes a frame of the given length
  function automatic logic is_final_byte(input int unsigned off, input int unsigned len);
    return (off + 1) == len;
  endfunction

endpackage

// File: rtl/slot_mem.sv
module slot_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/slot_req_fifo.sv
module slot_req_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slots_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (int'(cnt_q) == DEPTH);
  assign level = cnt_q;
  assign rdata = slots_q[rd_q];

  always_ff @(posedge clk) begin
    if (push) slots_q[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_next(wr_q);
      if (pop)  rd_q <= ptr_next(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import pkt_slot_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int OFF_W  = 6,
  parameter int LEN_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    head_vld,
  input  logic [SLOT_W-1:0]       head_slot,
  input  logic [LEN_W-1:0]        head_len,
  input  logic                    tx_ready,
  output logic                    head_pop,
  output logic [SLOT_W+OFF_W-1:0] rd_addr,
  output logic                    tx_valid,
  output logic                    tx_last,
  output logic                    frame_done,
  output logic [SLOT_W-1:0]       cur_slot
);
  seq_state_e        st_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [SLOT_W-1:0] slot_q;
  logic              beat;

  assign tx_valid   = (st_q == SEQ_SEND);
  assign tx_last    = tx_valid && is_final_byte(32'(off_q), 32'(len_q));
  assign beat       = tx_valid && tx_ready;
  assign frame_done = beat && tx_last;
  assign head_pop   = (st_q == SEQ_IDLE) && head_vld;
  assign rd_addr    = {slot_q, off_q};
  assign cur_slot   = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      off_q  <= '0;
      len_q  <= '0;
      slot_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (head_pop) begin
          slot_q <= head_slot;
          len_q  <= head_len;
          off_q  <= '0;
          st_q   <= SEQ_SEND;
        end
        SEQ_SEND: begin
          if (frame_done) st_q <= SEQ_IDLE;
          else if (beat)  off_q <= off_q + 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_slot_tx.sv
module pkt_slot_tx
  import pkt_slot_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 64,
  parameter int FIFO_DEPTH = 2,
  parameter int DONE_W     = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int OFF_W  = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1),
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mem_we,
  input  logic [SLOT_W+OFF_W-1:0] mem_addr,
  input  logic [7:0]              mem_wdata,
  input  logic                    start_we,
  input  logic [SLOT_W-1:0]       start_slot,
  input  logic [LEN_W-1:0]        start_len,
  output logic [NUM_SLOTS-1:0]    slot_busy,
  output logic                    req_ready,
  output logic [LVL_W-1:0]        req_level,
  output logic                    overflow,
  input  logic                    ack_we,
  output logic                    done_pending,
  output logic [DONE_W-1:0]       done_count,
  output logic [7:0]              tx_data,
  output logic                    tx_valid,
  output logic                    tx_last,
  input  logic                    tx_ready
);
  localparam int ADDR_W = SLOT_W + OFF_W;
  localparam int ENT_W  = SLOT_W + LEN_W;

  // named internal events, also watched by the checker
  logic                 fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic                 frame_done;
  logic [NUM_SLOTS-1:0] set_mask, done_mask;

  logic [NUM_SLOTS-1:0] busy_q;
  logic                 ovf_q;
  logic [DONE_W-1:0]    done_q;
  logic [ENT_W-1:0]     head_ent;
  logic [ADDR_W-1:0]    rd_addr;
  logic [SLOT_W-1:0]    cur_slot;
  logic                 slot_ok, len_ok, ack_take;

  assign slot_ok   = (int'(start_slot) < NUM_SLOTS) && !busy_q[start_slot];
  assign len_ok    = len_in_range(32'(start_len), SLOT_BYTES);
  assign fifo_push = start_we && slot_ok && len_ok && !fifo_full;
  assign ack_take  = ack_we && (done_q != '0);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      set_mask[i]  = fifo_push && (int'(start_slot) == i);
      done_mask[i] = frame_done && (int'(cur_slot) == i);
    end
  end

  slot_req_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .wdata({start_slot, start_len}),
    .pop(fifo_pop), .rdata(head_ent),
    .empty(fifo_empty), .full(fifo_full), .level(req_level)
  );

  tx_sequencer #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .head_vld(!fifo_empty),
    .head_slot(head_ent[ENT_W-1:LEN_W]), .head_len(head_ent[LEN_W-1:0]),
    .tx_ready(tx_ready), .head_pop(fifo_pop), .rd_addr(rd_addr),
    .tx_valid(tx_valid), .tx_last(tx_last),
    .frame_done(frame_done), .cur_slot(cur_slot)
  );

  slot_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(tx_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      ovf_q  <= 1'b0;
      done_q <= '0;
    end else begin
      busy_q <= (busy_q | set_mask) & ~done_mask;
      if (start_we && fifo_full) ovf_q <= 1'b1;
      case ({frame_done, ack_take})
        2'b10:   if (done_q != '1) done_q <= done_q + 1'b1;
        2'b01:   done_q <= done_q - 1'b1;
        default: done_q <= done_q;
      endcase
    end
  end

  assign slot_busy    = busy_q;
  assign req_ready    = !fifo_full;
  assign overflow     = ovf_q;
  assign done_count   = done_q;
  assign done_pending = (done_q != '0);
endmodule

// File: rtl/tx_slot_chk.sv
module tx_slot_chk #(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_BYTES = 64,
  parameter int FIFO_DEPTH = 2,
  parameter int DONE_W     = 4,
  parameter int SLOT_W     = 2,
  parameter int LEN_W      = 7,
  parameter int LVL_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_we,
  input logic [SLOT_W-1:0]    start_slot,
  input logic [LEN_W-1:0]     start_len,
  input logic [NUM_SLOTS-1:0] slot_busy,
  input logic                 req_ready,
  input logic [LVL_W-1:0]     req_level,
  input logic                 overflow,
  input logic                 ack_we,
  input logic                 done_pending,
  input logic [DONE_W-1:0]    done_count,
  input logic [7:0]           tx_data,
  input logic                 tx_valid,
  input logic                 tx_last,
  input logic                 tx_ready,
  input logic                 fifo_push,
  input logic                 frame_done,
  input logic [NUM_SLOTS-1:0] done_mask
);
  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R5
  free_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (slot_busy & $past(done_mask)) == '0);

  // R5
  one_slot_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_mask));

  // R6
  ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (int'(req_level) < FIFO_DEPTH));

  // R6
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we && !req_ready |-> !fifo_push);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we && (start_len == '0 || int'(start_len) > SLOT_BYTES) |-> !fifo_push);

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we && int'(start_slot) < NUM_SLOTS && slot_busy[start_slot] |-> !fifo_push);

  // R10
  pending_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pending == (done_count != '0));

  // R10
  ack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we && !frame_done && done_count != '0 |=> done_count == $past(done_count) - 1'b1);
endmodule

bind pkt_slot_tx tx_slot_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES), .FIFO_DEPTH(FIFO_DEPTH),
  .DONE_W(DONE_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_slot(start_slot),
  .start_len(start_len), .slot_busy(slot_busy), .req_ready(req_ready),
  .req_level(req_level), .overflow(overflow), .ack_we(ack_we),
  .done_pending(done_pending), .done_count(done_count), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
  .fifo_push(fifo_push), .frame_done(frame_done), .done_mask(done_mask)
);

// File: tb/test_pkt_slot_tx.sv
module test_pkt_slot_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_we = 1'b0;
  logic [7:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic       start_we = 1'b0;
  logic [1:0] start_slot = '0;
  logic [6:0] start_len = '0;
  logic [3:0] slot_busy;
  logic       req_ready;
  logic [1:0] req_level;
  logic       overflow;
  logic       ack_we = 1'b0;
  logic       done_pending;
  logic [3:0] done_count;
  logic [7:0] tx_data;
  logic       tx_valid, tx_last;
  logic       tx_ready = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_slot_tx i_pkt_slot_tx (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .start_we(start_we), .start_slot(start_slot),
    .start_len(start_len), .slot_busy(slot_busy), .req_ready(req_ready),
    .req_level(req_level), .overflow(overflow), .ack_we(ack_we),
    .done_pending(done_pending), .done_count(done_count), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] pat(input int slot, input int i, input int seed);
    return 8'(slot * 37 + i * 5 + seed);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_frame(input int slot, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      mem_we    = 1'b1;
      mem_addr  = {2'(slot), 6'(i)};
      mem_wdata = pat(slot, i, seed);
      @(negedge clk);
    end
    mem_we = 1'b0;
  endtask

  task automatic do_start(input int slot, input int len);
    start_we   = 1'b1;
    start_slot = 2'(slot);
    start_len  = 7'(len);
    @(negedge clk);
    start_we = 1'b0;
  endtask

  task automatic do_ack();
    ack_we = 1'b1;
    @(negedge clk);
    ack_we = 1'b0;
  endtask

  // collects one frame; stall_mode drops ready every third cycle
  task automatic recv_frame(input int slot, input int len, input int seed, input bit stall_mode);
    int got = 0;
    int guard = 0;
    bit held = 0;
    logic [7:0] hd = '0;
    logic hl = 1'b0;
    while (got < len && guard < 1000) begin
      tx_ready = stall_mode ? (guard % 3 != 0) : 1'b1;
      #1;
      if (held)  // R4 stalled byte must not move
        check(tx_valid && tx_data == hd && tx_last == hl, "R4", "stalled byte",
              int'(tx_data), int'(hd));
      held = 0;
      if (tx_valid) begin
        if (tx_ready) begin
          check(tx_data == pat(slot, got, seed), "R3/R9", "byte value",
                int'(tx_data), int'(pat(slot, got, seed)));
          check(tx_last == (got == len - 1), "R3", "last flag",
                int'(tx_last), int'(got == len - 1));
          got++;
        end else begin
          held = 1; hd = tx_data; hl = tx_last;
        end
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(got == len, "R3", "bytes received", got, len);
  endtask

  task automatic t_reset();
    check(slot_busy == 4'b0000, "R1", "busy mask", int'(slot_busy), 0);
    check(req_level == 2'd0, "R1", "level", int'(req_level), 0);
    check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    check(tx_valid == 1'b0, "R1", "tx_valid", int'(tx_valid), 0);
    check(done_pending == 1'b0 && done_count == 4'd0, "R1", "done count",
          int'(done_count), 0);
    check(overflow == 1'b0, "R1", "overflow", int'(overflow), 0);
  endtask

  task automatic t_single();
    write_frame(1, 5, 1);
    do_start(1, 5);
    check(slot_busy == 4'b0010, "R2", "busy after start", int'(slot_busy), 2);
    check(req_level == 2'd1, "R2", "level after start", int'(req_level), 1);
    recv_frame(1, 5, 1, 0);
    check(slot_busy == 4'b0000, "R5", "slot freed", int'(slot_busy), 0);
    check(done_count == 4'd1 && done_pending, "R10", "count after frame",
          int'(done_count), 1);
    do_ack();
    check(done_count == 4'd0 && !done_pending, "R10", "count after ack",
          int'(done_count), 0);
  endtask

  task automatic t_stall();
    write_frame(2, 4, 9);
    write_frame(3, 64, 20);
    do_start(2, 4);
    do_start(3, 64);  // R7 full slot size is accepted
    check(slot_busy == 4'b1100, "R7", "full-size start accepted", int'(slot_busy), 12);
    recv_frame(2, 4, 9, 1);
    check(slot_busy == 4'b1000, "R5", "first slot freed, second held",
          int'(slot_busy), 8);
    recv_frame(3, 64, 20, 1);
    check(done_count == 4'd2, "R10", "two completions", int'(done_count), 2);
    do_ack();
    check(done_count == 4'd1 && done_pending, "R10", "one left", int'(done_count), 1);
    do_ack();
    check(done_count == 4'd0 && !done_pending, "R10", "none left", int'(done_count), 0);
  endtask

  task automatic t_reject();
    do_start(0, 0);
    check(slot_busy == 4'b0000, "R7", "zero length busy", int'(slot_busy), 0);
    check(req_level == 2'd0, "R7", "zero length level", int'(req_level), 0);
    do_start(0, 65);
    check(slot_busy == 4'b0000, "R7", "oversize busy", int'(slot_busy), 0);
    check(req_level == 2'd0, "R7", "oversize level", int'(req_level), 0);
    tx_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!tx_valid, "R7", "no frame from rejected start", int'(tx_valid), 0);
    end
    tx_ready = 1'b0;
  endtask

  task automatic t_busy();
    write_frame(0, 2, 7);
    tx_ready = 1'b0;
    do_start(0, 2);
    do_start(0, 3);
    check(req_level == 2'd0, "R8", "busy slot not queued", int'(req_level), 0);
    check(slot_busy == 4'b0001, "R8", "busy mask", int'(slot_busy), 1);
    recv_frame(0, 2, 7, 0);
    tx_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!tx_valid, "R8", "no second frame", int'(tx_valid), 0);
    end
    tx_ready = 1'b0;
    do_ack();
  endtask

  task automatic t_full();
    write_frame(0, 2, 3);
    write_frame(1, 3, 4);
    write_frame(2, 1, 5);
    write_frame(3, 2, 6);
    tx_ready = 1'b0;
    do_start(0, 2);
    do_start(1, 3);
    do_start(2, 1);
    check(req_level == 2'd2, "R2", "level when full", int'(req_level), 2);
    check(req_ready == 1'b0, "R6", "ready low when full", int'(req_ready), 0);
    check(overflow == 1'b0, "R6", "no overflow yet", int'(overflow), 0);
    do_start(3, 2);
    check(overflow == 1'b1, "R6", "overflow set", int'(overflow), 1);
    check(slot_busy == 4'b0111, "R6", "ignored start busy mask", int'(slot_busy), 7);
    check(req_level == 2'd2, "R6", "ignored start level", int'(req_level), 2);
    recv_frame(0, 2, 3, 0);  // R9 order of acceptance
    recv_frame(1, 3, 4, 0);
    recv_frame(2, 1, 5, 0);
    check(done_count == 4'd3, "R10", "three completions", int'(done_count), 3);
    for (int k = 2; k >= 0; k--) begin
      do_ack();
      check(int'(done_count) == k && done_pending == (k != 0), "R10",
            "count after ack", int'(done_count), k);
    end
    check(overflow == 1'b1, "R6", "overflow sticky", int'(overflow), 1);
    check(req_ready == 1'b1, "R6", "ready after drain", int'(req_ready), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_stall();
    t_reject();
    t_busy();
    t_full();
    summary();
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      summary();
    end
  end
endmodule